// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full Indication

This block is a first-in first-out buffer of 16-bit words. Its write side and read side each run on their own clock. The two clocks may be unrelated or may be one shared clock. A producer stores a word on any write-clock rising edge where its active-low write request is low and the buffer has room. A consumer pulls words into a holding output register with an active-low read request on the read clock.

Reads work in standard mode. Nothing reaches the output register until a read is requested, and that includes the first word written into an empty buffer. Three active-low status outputs report the buffer state: nothing to read, no room to write, and more than half the depth occupied. An active-low output enable either drives the held word onto a shared data bus or releases the bus to high impedance. One active-low reset brings both sides back to their starting state.

The depth is a power-of-two parameter with a default of 512. Each pointer crosses to the other clock domain as a Gray-coded value one bit wider than the address. This makes both boundary flags conservative: a flag may release late, but it never claims room or data that does not exist.

Top module: `dual_clk_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only when the write request is low and the no-room flag is high. A high write request stores nothing and leaves every flag unchanged.
- R2: On a read-clock rising edge with the read request low and the nothing-to-read flag high, the oldest word is loaded into the output register. Otherwise the register keeps its value. A word written into an empty buffer does not reach the output without a read request.
- R3: With no reads since reset, the no-room flag goes low on the write edge that stores the DEPTH-th word. While the flag is low, further write requests are dropped.
- R4: The nothing-to-read flag goes low on the read edge that takes the last stored word. After a write it returns high on the third read edge following the write edge, or at the latest on the fourth. It is never high on the first read edge after the write.
- R5: The half flag goes low on the write edge that stores the (DEPTH/2+1)-th unread word. Once occupancy is DEPTH/2 or less and both clocks have run a few edges, the flag is high. When the no-room flag is low, the half flag is also low.
- R6: While reset is low, the output register is zero, the nothing-to-read flag is low, the no-room flag is high and the half flag is high.
- R7: With the output enable low, the bus carries the output register. With it high, the block drives no value onto the bus.
- R8: After a read frees a location in a full buffer, the no-room flag stays low on that edge. It goes high within four write edges.
- R9: Words leave in the order they were accepted, with none lost or duplicated. This holds with tied clocks and with clocks of unrelated period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEnN | input | 1 | Write request, active low |
| wrData | input | DW (16) | Word to store |
| rdClk | input | 1 | Read-side clock |
| rdEnN | input | 1 | Read request, active low |
| oeN | input | 1 | Output bus enable, active low |
| rstN | input | 1 | Reset, active low, both domains |
| dataBus | inout | DW (16) | Output register when enabled, high impedance otherwise |
| emptyN | output | 1 | Low when nothing is available to read (read domain) |
| fullN | output | 1 | Low when no room is left (write domain) |
| halfN | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
A pointer that skips or repeats an entry appears at the bus on the very next read: the word is out of order, duplicated or missing, so a scoreboard that follows the accepted transfers catches it at that read. A synchroniser or Gray-compare fault shows up at the flags instead. The flag either releases too early, which lets a write overrun stored data or a read return a stale word within a few edges, or it never releases, which is visible as soon as both clocks have idled for a handful of edges. Occupancy thresholds are swept one word at a time on a small depth, so an off-by-one at half or full is visible on the exact edge where it occurs.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // strobes from the control block to the storage block
  typedef struct packed {
    logic push;   // write-clock domain: store wrData at the write address
    logic pop;    // read-clock domain: load the output register from the read address
  } dcf_strobe_t;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic                     wrEnN,
  input  logic                     rdEnN,
  output dcf_strobe_t              strb,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     fullN,
  output logic                     emptyN,
  output logic                     halfN
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PW-1:0] wrBin, wrGray, wrBinNx, wrGrayNx, rdGrayW, rdBinW, wrOcc;
  logic          fullReg, hfW, wrInc;

  // read domain
  logic [PW-1:0] rdBin, rdGray, rdBinNx, rdGrayNx, wrGrayR, wrBinR, rdOcc;
  logic          emptyReg, hfR, rdInc;

  dcf_sync #(.W(PW)) syncRdToWr (.clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGrayW));
  dcf_sync #(.W(PW)) syncWrToRd (.clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGrayR));

  always_comb begin
    wrInc    = !wrEnN && !fullReg;
    wrBinNx  = wrBin + PW'(wrInc);
    wrGrayNx = toGray(wrBinNx);
    rdBinW   = toBin(rdGrayW);
    wrOcc    = wrBinNx - rdBinW;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      fullReg <= 1'b0;
      hfW     <= 1'b0;
    end else begin
      wrBin   <= wrBinNx;
      wrGray  <= wrGrayNx;
      fullReg <= (wrGrayNx == {~rdGrayW[PW-1:PW-2], rdGrayW[PW-3:0]});
      hfW     <= (wrOcc > PW'(HALF));
    end
  end

  always_comb begin
    rdInc    = !rdEnN && !emptyReg;
    rdBinNx  = rdBin + PW'(rdInc);
    rdGrayNx = toGray(rdBinNx);
    wrBinR   = toBin(wrGrayR);
    rdOcc    = wrBinR - rdBinNx;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      emptyReg <= 1'b1;
      hfR      <= 1'b0;
    end else begin
      rdBin    <= rdBinNx;
      rdGray   <= rdGrayNx;
      emptyReg <= (rdGrayNx == wrGrayR);
      hfR      <= (rdOcc > PW'(HALF));
    end
  end

  assign strb.push = wrInc;
  assign strb.pop  = rdInc;
  assign wrAddr    = wrBin[AW-1:0];
  assign rdAddr    = rdBin[AW-1:0];
  assign fullN     = !fullReg;
  assign emptyN    = !emptyReg;
  // set by the write view, held until both views have dropped to half or less
  assign halfN     = !(hfW || hfR);

endmodule

// File: rtl/dcf_data.sv
module dcf_data
  import dcf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 16
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  dcf_strobe_t              strb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DW-1:0]            wrData,
  output logic [DW-1:0]            rdWord
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         rdWord <= '0;
    else if (strb.pop) rdWord <= mem[rdAddr];
  end

endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 16
) (
  input  logic          wrClk,
  input  logic          wrEnN,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdEnN,
  input  logic          oeN,
  input  logic          rstN,
  inout  wire  [DW-1:0] dataBus,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfN
);

  localparam int AW = $clog2(DEPTH);

  dcf_strobe_t   strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [DW-1:0] rdWord;

  dcf_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .rdEnN(rdEnN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .halfN(halfN)
  );

  dcf_data #(.DEPTH(DEPTH), .DW(DW)) dataI (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdWord(rdWord)
  );

  assign dataBus = oeN ? {DW{1'bz}} : rdWord;

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wrEnN,
  input logic          rdEnN,
  input logic          fullN,
  input logic          emptyN,
  input logic          halfN,
  input logic [AW-1:0] wrAddr,
  input logic [DW-1:0] rdWord
);

  p_idle_write_r1: assert property (@(posedge wrClk) disable iff (!rstN)
    wrEnN |=> $stable(wrAddr));

  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrAddr));

  p_idle_read_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEnN |=> $stable(rdWord));

  p_no_underflow_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdWord));

  p_full_implies_half_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !halfN);

  p_reset_state_r6: assert property (@(posedge rdClk)
    !rstN |-> (!emptyN && fullN && halfN && rdWord == '0));

endmodule

bind dual_clk_fifo dcf_checker #(.AW(AW), .DW(DW)) chkI (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEnN(wrEnN), .rdEnN(rdEnN),
  .fullN(fullN), .emptyN(emptyN), .halfN(halfN),
  .wrAddr(wrAddr), .rdWord(rdWord)
);

// File: tb/dual_clk_fifo_tb_top.sv
`timescale 1ns/100ps
module dual_clk_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int HALF       = DEPTH / 2;

  logic        wrClk = 0, rdClk = 0;
  logic        wrEnN = 1, rdEnN = 1, oeN = 0, rstN = 1;
  logic [15:0] wrData = '0;
  logic        benchDrive = 0;
  wire  [15:0] bus;
  logic        emptyN, fullN, halfN;

  int wrHalf = CLK_PERIOD / 2;
  int rdHalf = CLK_PERIOD / 2;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] q[$];
  logic [15:0] expWord, lastRead = '0;
  bit          pendCmp = 0;

  assign bus = benchDrive ? 16'hA5A5 : 16'hzzzz;

  dual_clk_fifo #(.DEPTH(DEPTH), .DW(16)) dut_i (
    .wrClk(wrClk), .wrEnN(wrEnN), .wrData(wrData),
    .rdClk(rdClk), .rdEnN(rdEnN), .oeN(oeN), .rstN(rstN),
    .dataBus(bus), .emptyN(emptyN), .fullN(fullN), .halfN(halfN)
  );

  always #(wrHalf) wrClk = ~wrClk;
  always #(rdHalf) rdClk = ~rdClk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: follows accepted transfers seen at the ports
  always @(posedge wrClk) begin
    if (rstN && !wrEnN && fullN) begin
      q.push_back(wrData);
      if (q.size() > DEPTH) chk(0, "R3 overflow", q.size(), DEPTH);
    end
  end

  always @(posedge rdClk) begin
    if (rstN && !rdEnN && emptyN) begin
      if (q.size() == 0) chk(0, "R2 underflow", 0, 1);
      else begin
        expWord = q.pop_front();
        pendCmp = 1;
      end
    end
  end

  always @(negedge rdClk) begin
    if (pendCmp) begin
      pendCmp = 0;
      chk(bus == expWord, "R9 data order", bus, expWord);
      lastRead = expWord;
    end
  end

  task automatic wrEdges(input int n);
    repeat (n) @(negedge wrClk);
  endtask

  task automatic randRound(input int n, input int wrPct, input int rdPct);
    fork
      begin
        repeat (n) begin
          @(negedge wrClk);
          wrEnN  = ($urandom % 100) >= wrPct;
          wrData = 16'($urandom);
        end
        @(negedge wrClk) wrEnN = 1;
      end
      begin
        repeat (n) begin
          @(negedge rdClk);
          rdEnN = ($urandom % 100) >= rdPct;
        end
        @(negedge rdClk) rdEnN = 1;
      end
    join
    repeat (10) @(negedge rdClk);
    repeat (2) @(negedge wrClk);
    chk(emptyN == (q.size() > 0), "R4 settled empty flag", emptyN, q.size() > 0);
    chk(fullN == (q.size() < DEPTH), "R3 settled full flag", fullN, q.size() < DEPTH);
    chk(halfN == !(q.size() > HALF), "R5 settled half flag", halfN, !(q.size() > HALF));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rstN = 0;
    wrEdges(3);
    // R6: reset state
    chk(emptyN == 0, "R6 empty at reset", emptyN, 0);
    chk(fullN == 1, "R6 full at reset", fullN, 1);
    chk(halfN == 1, "R6 half at reset", halfN, 1);
    chk(bus == 16'h0, "R6 output register cleared", bus, 0);
    rstN = 1;
    wrEdges(2);

    // R2/R4: single word, tied clocks, no fall-through
    wrEnN = 0; wrData = 16'h1111;
    @(negedge wrClk) wrEnN = 1;
    chk(emptyN == 0, "R4 no early empty release", emptyN, 0);
    wrEdges(3);
    chk(emptyN == 1, "R4 empty release after write", emptyN, 1);
    chk(bus == 16'h0, "R2 first word needs a read", bus, 0);
    rdEnN = 0;
    @(negedge wrClk) rdEnN = 1;
    chk(emptyN == 0, "R4 empty on last read", emptyN, 0);
    chk(bus == 16'h1111, "R2 read loads word", bus, 16'h1111);

    // R1: high write request stores nothing
    wrData = 16'hBEEF;
    wrEdges(6);
    chk(emptyN == 0, "R1 idle write stores nothing", emptyN, 0);
    chk(halfN == 1, "R1 idle write half flag", halfN, 1);
    rdEnN = 0;
    wrEdges(2);
    rdEnN = 1;
    chk(bus == 16'h1111, "R2 read while empty ignored", bus, 16'h1111);

    // R3/R5: fill one word at a time
    for (int k = 1; k <= DEPTH; k++) begin
      wrEnN = 0; wrData = 16'h0100 + 16'(k - 1);
      @(negedge wrClk) wrEnN = 1;
      chk(halfN == !(k > HALF), "R5 half threshold", halfN, !(k > HALF));
      chk(fullN == !(k == DEPTH), "R3 full threshold", fullN, !(k == DEPTH));
    end
    wrEnN = 0; wrData = 16'hDEAD;
    wrEdges(3);
    wrEnN = 1;
    chk(fullN == 0, "R3 full holds while writes dropped", fullN, 0);
    chk(q.size() == DEPTH, "R3 writes dropped when full", q.size(), DEPTH);

    // R8: release after one read
    rdEnN = 0;
    @(negedge wrClk) rdEnN = 1;
    chk(fullN == 0, "R8 no early full release", fullN, 0);
    wrEdges(3);
    chk(fullN == 1, "R8 full release after read", fullN, 1);
    chk(halfN == 0, "R5 still above half", halfN, 0);

    // drain
    rdEnN = 0;
    wrEdges(DEPTH + 4);
    rdEnN = 1;
    wrEdges(5);
    chk(emptyN == 0, "R4 empty after drain", emptyN, 0);
    chk(halfN == 1, "R5 half release after drain", halfN, 1);
    chk(fullN == 1, "R3 not full after drain", fullN, 1);
    chk(q.size() == 0, "R9 nothing lost", q.size(), 0);

    // R7: bus release
    oeN = 1; benchDrive = 1;
    wrEdges(1);
    chk(bus == 16'hA5A5, "R7 bus released", bus, 16'hA5A5);
    benchDrive = 0; oeN = 0;
    wrEdges(1);
    chk(bus == 16'h010F, "R7 bus shows register", bus, 16'h010F);

    // R9: random traffic, tied clocks then unrelated periods
    randRound(2000, 70, 40);
    randRound(2000, 40, 70);
    rdHalf = 7;
    randRound(3000, 80, 50);
    randRound(3000, 50, 90);
    wrHalf = 8;
    randRound(3000, 60, 60);

    rdEnN = 0;
    repeat (DEPTH + 10) @(negedge rdClk);
    rdEnN = 1;
    repeat (4) @(negedge rdClk);
    chk(q.size() == 0, "R9 final drain complete", q.size(), 0);
    chk(emptyN == 0, "R4 empty after final drain", emptyN, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule